// File: doc/BRIEF.md
# Element Saturation Clamp Unit

This block takes one integer element result and clamps it into the range of a chosen destination element width. The result arrives already computed at the wider of the source and destination widths, with two extra headroom bits so that any overflow past the destination range can still be seen. The destination width may be 8, 16, 32 or 64 bits and can change from one element to the next. A mode input chooses between an unsigned range and a signed range.

The clamped value is returned as a full 64-bit word. It is sign-extended in signed mode and zero-extended in unsigned mode. A per-element overflow bit reports whether clamping took place. This bit is meant for the overflow position of that element's condition field. It is driven only when the record flag is set, and it never depends on a sticky summary-overflow flag. Requesting saturation together with the overflow-enable flag is an illegal combination, and the block reports it on a strobe. The block is purely combinational and is placed after the element ALU of a vector pipeline.

Top module: `elem_sat_clamp`

## Requirements
- R1: The destination width code `elemWidth` selects the width: 0 is 64 bits, 1 is 32 bits, 2 is 16 bits, 3 is 8 bits. A wide result that lies inside the selected range comes out unchanged in its low width bits.
- R2: With `signedSat`=0, a non-negative wide result above 2^w-1 gives 2^w-1, where w is the selected width.
- R3: With `signedSat`=0, a negative wide result, as seen by the sign bit of the 66-bit input, gives 0.
- R4: With `signedSat`=1, a wide result above 2^(w-1)-1 gives 2^(w-1)-1, and a result below -2^(w-1) gives -2^(w-1).
- R5: `elemOut` is the w-bit clamped value. It is sign-extended to 64 bits when `signedSat`=1 and zero-extended when `signedSat`=0.
- R6: With `rcFlag`=1 and `oeFlag`=0, `ovBit` is 1 exactly when clamping changed the value. With `rcFlag`=0, `ovBit` is 0.
- R7: `oeFlag`=1 drives `illegalStb` to 1 and forces `ovBit` to 0. With `oeFlag`=0, `illegalStb` is 0.
- R8: Values exactly equal to a range limit pass through without setting `ovBit`, while the value one step beyond a limit is clamped.
- R9: At the 64-bit width, the two headroom bits are used to detect overflow. The signed value 2^63 and the unsigned value 2^64 are both clamped.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| wideRes | input | 66 | Element result in two's complement, computed at the wider width, with headroom |
| elemWidth | input | 2 | Destination width code (0:64, 1:32, 2:16, 3:8) |
| signedSat | input | 1 | 1 selects the signed range, 0 selects the unsigned range |
| oeFlag | input | 1 | Overflow-enable flag of the instruction |
| rcFlag | input | 1 | Record flag: enables the per-element overflow bit |
| elemOut | output | 64 | Clamped element, extended to 64 bits |
| ovBit | output | 1 | Saturation indication for the element's condition field |
| illegalStb | output | 1 | Illegal-instruction strobe for saturation with overflow-enable |

## Verification
The bench builds the block with its defaults: a 64-bit data word, two headroom bits, and all four lane widths generated. These defaults make it possible to reach the widest lane, where only the headroom bits show an overflow, and the 8-bit lane, where nearly all of the input lies above the clamp point. At each width the bench checks the values just inside and just outside both limits in both modes. It also checks negative inputs in unsigned mode, and how the flags combine when the record flag is clear or the overflow-enable flag is set.

// File: rtl/elem_sat_pkg.sv
package elem_sat_pkg;

  // number of destination widths, each half the previous one
  localparam int NUM_LANES = 4;

  typedef enum logic [1:0] {
    EW_64 = 2'd0,
    EW_32 = 2'd1,
    EW_16 = 2'd2,
    EW_8  = 2'd3
  } elemWidthT;

  // strobes from the control to the datapath
  typedef struct packed {
    logic [NUM_LANES-1:0] laneSel;     // one-hot lane select
    logic                 signedMode;  // signed clamp range
    logic                 reportOv;    // allow saturation onto the condition bit
    logic                 raiseIll;    // illegal flag combination
  } satStrobesT;

endpackage

// File: rtl/elem_sat_ctrl.sv
module elem_sat_ctrl
  import elem_sat_pkg::*;
(
  input  logic [1:0]  elemWidth,
  input  logic        signedSat,
  input  logic        oeFlag,
  input  logic        rcFlag,
  output satStrobesT  strobes
);

  logic [NUM_LANES-1:0] laneDec;

  // lane k has width DATA_W >> k, so the width code indexes the lane directly
  always_comb begin
    laneDec = '0;
    for (int k = 0; k < NUM_LANES; k++) begin
      if (elemWidth == 2'(k)) laneDec[k] = 1'b1;
    end
  end

  always_comb begin
    strobes.laneSel    = laneDec;
    strobes.signedMode = signedSat;
    // overflow enable conflicts with the saturation report: no report then
    strobes.reportOv   = rcFlag & ~oeFlag;
    strobes.raiseIll   = oeFlag;
  end

endmodule

// File: rtl/elem_sat_lane.sv
module elem_sat_lane #(
  parameter int DATA_W = 64,
  parameter int RES_W  = 66,
  parameter int LANE_W = 64
) (
  input  logic [RES_W-1:0]  wideRes,
  input  logic              signedMode,
  output logic [DATA_W-1:0] laneVal,
  output logic              laneHit
);

  localparam int TOP_W = RES_W - LANE_W + 1;

  logic [TOP_W-1:0]  topBits;
  logic              sOver;
  logic              wideNeg;
  logic              uOver;
  logic [DATA_W-1:0] lowZero;
  logic [DATA_W-1:0] lowSign;
  logic [DATA_W-1:0] sMax;
  logic [DATA_W-1:0] sMin;
  logic [DATA_W-1:0] uMax;

  // signed: every bit from the lane sign bit upward must agree
  assign topBits = wideRes[RES_W-1:LANE_W-1];
  assign sOver   = ~((&topBits) | ~(|topBits));

  // unsigned: negative input, or any set bit between the lane and the sign
  assign wideNeg = wideRes[RES_W-1];
  assign uOver   = ~wideNeg & (|wideRes[RES_W-2:LANE_W]);

  assign lowZero = DATA_W'(wideRes[LANE_W-1:0]);
  assign lowSign = lowZero | ({DATA_W{wideRes[LANE_W-1]}} << LANE_W);

  assign sMax = {DATA_W{1'b1}} >> (DATA_W - LANE_W + 1);
  assign sMin = ~sMax;
  assign uMax = {DATA_W{1'b1}} >> (DATA_W - LANE_W);

  always_comb begin
    if (signedMode) begin
      if (sOver) laneVal = wideNeg ? sMin : sMax;
      else       laneVal = lowSign;
      laneHit = sOver;
    end else begin
      if (wideNeg)    laneVal = '0;
      else if (uOver) laneVal = uMax;
      else            laneVal = lowZero;
      laneHit = wideNeg | uOver;
    end
  end

endmodule

// File: rtl/elem_sat_datapath.sv
module elem_sat_datapath
  import elem_sat_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HEAD_W = 2,
  localparam int RES_W = DATA_W + HEAD_W
) (
  input  logic [RES_W-1:0]  wideRes,
  input  satStrobesT        strobes,
  output logic [DATA_W-1:0] elemOut,
  output logic              ovBit
);

  logic [DATA_W-1:0] laneVal [NUM_LANES];
  logic [NUM_LANES-1:0] laneHit;
  logic [DATA_W-1:0] muxVal;
  logic              muxHit;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    elem_sat_lane #(
      .DATA_W (DATA_W),
      .RES_W  (RES_W),
      .LANE_W (DATA_W >> k)
    ) u_lane (
      .wideRes    (wideRes),
      .signedMode (strobes.signedMode),
      .laneVal    (laneVal[k]),
      .laneHit    (laneHit[k])
    );
  end

  // one-hot AND-OR mux across the lanes
  always_comb begin
    muxVal = '0;
    muxHit = 1'b0;
    for (int k = 0; k < NUM_LANES; k++) begin
      muxVal = muxVal | (laneVal[k] & {DATA_W{strobes.laneSel[k]}});
      muxHit = muxHit | (laneHit[k] & strobes.laneSel[k]);
    end
  end

  assign elemOut = muxVal;
  assign ovBit   = muxHit & strobes.reportOv;

endmodule

// File: rtl/elem_sat_clamp.sv
module elem_sat_clamp
  import elem_sat_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HEAD_W = 2,
  localparam int RES_W = DATA_W + HEAD_W
) (
  input  logic [RES_W-1:0]  wideRes,
  input  logic [1:0]        elemWidth,
  input  logic              signedSat,
  input  logic              oeFlag,
  input  logic              rcFlag,
  output logic [DATA_W-1:0] elemOut,
  output logic              ovBit,
  output logic              illegalStb
);

  satStrobesT strobes;

  elem_sat_ctrl u_ctrl (
    .elemWidth (elemWidth),
    .signedSat (signedSat),
    .oeFlag    (oeFlag),
    .rcFlag    (rcFlag),
    .strobes   (strobes)
  );

  elem_sat_datapath #(
    .DATA_W (DATA_W),
    .HEAD_W (HEAD_W)
  ) u_dp (
    .wideRes (wideRes),
    .strobes (strobes),
    .elemOut (elemOut),
    .ovBit   (ovBit)
  );

  assign illegalStb = strobes.raiseIll;

endmodule

// File: rtl/elem_sat_checker.sv
module elem_sat_checker #(
  parameter int DATA_W = 64,
  parameter int HEAD_W = 2,
  localparam int RES_W = DATA_W + HEAD_W
) (
  input logic [RES_W-1:0]  wideRes,
  input logic [1:0]        elemWidth,
  input logic              signedSat,
  input logic              oeFlag,
  input logic              rcFlag,
  input logic [DATA_W-1:0] elemOut,
  input logic              ovBit,
  input logic              illegalStb
);

  int unsigned       wSel;
  logic [DATA_W-1:0] lowMask;
  logic [DATA_W-1:0] sextView;

  always_comb begin
    wSel     = DATA_W >> elemWidth;
    lowMask  = {DATA_W{1'b1}} >> (DATA_W - wSel);
    sextView = DATA_W'($signed(elemOut << (DATA_W - wSel)) >>> (DATA_W - wSel));
  end

  always_comb begin
    if (!$isunknown({elemWidth, signedSat, oeFlag, rcFlag})) begin
      // R5: unsigned results carry nothing above the element width
      a_r5_zero_ext: assert (signedSat || ((elemOut & ~lowMask) == '0));
      // R5: signed results are a sign extension of the element
      a_r5_sign_ext: assert (!signedSat || (elemOut == sextView));
      // R6: the condition bit needs the record flag
      a_r6_needs_rc: assert (!ovBit || rcFlag);
      // R7: strobe follows the overflow-enable flag and silences the report
      a_r7_oe_strobe: assert (illegalStb == oeFlag);
      a_r7_oe_quiet:  assert (!illegalStb || !ovBit);
      // R1: an unreported, reportable element keeps its low bits
      a_r1_pass_low: assert (!(rcFlag && !oeFlag && !ovBit) ||
                             ((elemOut & lowMask) == (DATA_W'(wideRes) & lowMask)));
    end
  end

endmodule

bind elem_sat_clamp elem_sat_checker #(
  .DATA_W (DATA_W),
  .HEAD_W (HEAD_W)
) u_chk (
  .wideRes    (wideRes),
  .elemWidth  (elemWidth),
  .signedSat  (signedSat),
  .oeFlag     (oeFlag),
  .rcFlag     (rcFlag),
  .elemOut    (elemOut),
  .ovBit      (ovBit),
  .illegalStb (illegalStb)
);

// File: tb/sim_elem_sat_clamp.sv
module sim_elem_sat_clamp;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [65:0] wideRes = '0;
  logic [1:0]  elemWidth = '0;
  logic        signedSat = 1'b0;
  logic        oeFlag = 1'b0;
  logic        rcFlag = 1'b0;
  logic [63:0] elemOut;
  logic        ovBit;
  logic        illegalStb;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  elem_sat_clamp u0 (
    .wideRes    (wideRes),
    .elemWidth  (elemWidth),
    .signedSat  (signedSat),
    .oeFlag     (oeFlag),
    .rcFlag     (rcFlag),
    .elemOut    (elemOut),
    .ovBit      (ovBit),
    .illegalStb (illegalStb)
  );

  // reference built from the stated ranges using wide signed arithmetic
  function automatic void refModel(input logic [65:0] wr, input logic [1:0] ew,
                                   input logic n, output logic [63:0] o,
                                   output logic hit);
    int w = 64 >> ew;
    logic signed [67:0] one = 68'sd1;
    logic signed [67:0] v;
    logic signed [67:0] lo;
    logic signed [67:0] hi;
    logic signed [67:0] c;
    v = {{2{wr[65]}}, wr};
    if (n) begin
      hi = (one <<< (w - 1)) - one;
      lo = -(one <<< (w - 1));
    end else begin
      hi = (one <<< w) - one;
      lo = '0;
    end
    hit = (v > hi) || (v < lo);
    c = (v > hi) ? hi : ((v < lo) ? lo : v);
    o = c[63:0];
  endfunction

  task automatic runCase(input string req, input logic [65:0] wr, input logic [1:0] ew,
                         input logic n, input logic oe, input logic rc);
    logic [63:0] expOut;
    logic        hit;
    logic        expOv;
    @(posedge clk);
    wideRes = wr; elemWidth = ew; signedSat = n; oeFlag = oe; rcFlag = rc;
    @(negedge clk);
    refModel(wr, ew, n, expOut, hit);
    expOv = hit & rc & ~oe;
    total++;
    if (elemOut !== expOut || ovBit !== expOv || illegalStb !== oe) begin
      bad++;
      $display("FAIL %s in=%h ew=%0d n=%0b oe=%0b rc=%0b: out=%h ov=%0b ill=%0b exp out=%h ov=%0b ill=%0b",
               req, wr, ew, n, oe, rc, elemOut, ovBit, illegalStb, expOut, expOv, oe);
    end
  endtask

  task automatic tReset();
    @(negedge clk);
    total++;
    if (elemOut !== 64'd0 || ovBit !== 1'b0 || illegalStb !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: out=%h ov=%0b ill=%0b exp out=0 ov=0 ill=0",
               elemOut, ovBit, illegalStb);
    end
  endtask

  task automatic tInRange();
    for (int ew = 0; ew < 4; ew++) begin
      runCase("R1", 66'h5, 2'(ew), 1'b0, 1'b0, 1'b1);
      runCase("R1", 66'h3fffffffffffffffd, 2'(ew), 1'b1, 1'b0, 1'b1);
      runCase("R5", 66'h3fffffffffffffff0, 2'(ew), 1'b1, 1'b0, 1'b1);
    end
  endtask

  task automatic tUnsignedHigh();
    runCase("R2", 66'h100, 2'd3, 1'b0, 1'b0, 1'b1);
    runCase("R2", 66'h12345, 2'd2, 1'b0, 1'b0, 1'b1);
    runCase("R2", 66'h1_0000_0000, 2'd1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic tUnsignedNeg();
    for (int ew = 0; ew < 4; ew++)
      runCase("R3", 66'h3ffffffffffffff80, 2'(ew), 1'b0, 1'b0, 1'b1);
  endtask

  task automatic tSignedClamp();
    runCase("R4", 66'h80, 2'd3, 1'b1, 1'b0, 1'b1);
    runCase("R4", 66'h3ffffffffffffff7f, 2'd3, 1'b1, 1'b0, 1'b1);
    runCase("R4", 66'h9000, 2'd2, 1'b1, 1'b0, 1'b1);
    runCase("R4", 66'h3ffffffff00000000, 2'd1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic tBoundaries();
    runCase("R8", 66'hff, 2'd3, 1'b0, 1'b0, 1'b1);
    runCase("R8", 66'h7f, 2'd3, 1'b1, 1'b0, 1'b1);
    runCase("R8", 66'h3ffffffffffffff80, 2'd3, 1'b1, 1'b0, 1'b1);
    runCase("R8", 66'h7fff, 2'd2, 1'b1, 1'b0, 1'b1);
    runCase("R8", 66'h8000, 2'd2, 1'b1, 1'b0, 1'b1);
    runCase("R8", 66'hffff_ffff, 2'd1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic tWide64();
    runCase("R9", 66'h0_8000_0000_0000_0000, 2'd0, 1'b1, 1'b0, 1'b1);
    runCase("R9", 66'h1_0000_0000_0000_0000, 2'd0, 1'b0, 1'b0, 1'b1);
    runCase("R9", 66'h0_ffff_ffff_ffff_ffff, 2'd0, 1'b0, 1'b0, 1'b1);
    runCase("R9", 66'h2_8000_0000_0000_0000, 2'd0, 1'b1, 1'b0, 1'b1);
    runCase("R9", 66'h3_8000_0000_0000_0000, 2'd0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic tFlags();
    runCase("R6", 66'h200, 2'd3, 1'b0, 1'b0, 1'b0);
    runCase("R6", 66'h200, 2'd3, 1'b1, 1'b0, 1'b1);
    runCase("R6", 66'h20, 2'd3, 1'b1, 1'b0, 1'b1);
    runCase("R7", 66'h200, 2'd3, 1'b1, 1'b1, 1'b1);
    runCase("R7", 66'h20, 2'd2, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    tReset();
    tInRange();
    tUnsignedHigh();
    tUnsignedNeg();
    tSignedClamp();
    tBoundaries();
    tWide64();
    tFlags();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run hung, exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule